// File: doc/BRIEF.md
# Extended-Address Management Read Master

This block is a serial management master for PHYs that use extended (two-step) register addressing. One request from the host makes two frames on the management bus, one straight after the other. The first is an address frame. It names a port, a device inside that port, and a 16-bit register address within that device. The second is a read frame. It returns the 16-bit contents of the register the address frame selected.

The host presents a port number, a device number and a register address, then pulses `start`. The block drives the management clock, the data line and the data-line enable. It samples the incoming data line itself. The block holds `busy` high for the whole exchange. When the second frame ends, `done` pulses for one cycle and the read value appears on `rdData`. The management clock half-period is derived from the system clock frequency so that no half-period is shorter than a set minimum (300 ns by default). That minimum leaves the device time to present its data before the master samples.

Top module: `mgmt_ext_reader`

## Requirements
- R1: Each of the two frames opens with 32 MDC cycles during which the master drives the data line (enable 1) at logic 1.
- R2: After the first preamble, the master drives 16 header bits, MSB first, one per MDC cycle. The bits are 0,0 (start), 0,0 (address opcode), the 5-bit port, the 5-bit device, then 1,0.
- R3: The 16-bit register address follows the R2 header at once, MSB first. After it comes one MDC cycle with the data line released (enable 0).
- R4: The second preamble follows that released cycle directly, with no idle or other cycle between them. After the preamble come 14 driven bits, MSB first: 0,0, 1,1 (read opcode), the 5-bit port, the 5-bit device.
- R5: After the 14 read-header bits, the line stays released for one turnaround cycle and then for 16 data cycles. The master takes one input bit per data cycle, MSB first. It samples each bit on the system clock cycle just after MDC falls, never at the rising edge.
- R6: One further released MDC cycle follows the last data cycle before `done` rises. The whole exchange is exactly 129 MDC cycles.
- R7: Every MDC half-period lasts at least ceil(MIN_HALF_NS × CLK_FREQ_HZ / 1e9) system clocks (30 at the defaults). The driven data only changes when MDC falls. MDC is low and the line is released whenever the block is idle.
- R8: `busy` is 1 from the cycle after an accepted `start` until the cycle that `done` is 1. `done` is a single-cycle pulse in the cycle `busy` falls. `rdData` holds the read value from that cycle until the next `done`.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. The frames in progress and the returned data are unchanged.
- R10: After reset, `mdc`, `mdioOe`, `busy`, `done` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, accepted when idle |
| phyAddr | input | 5 | Port number for both frames |
| devAddr | input | 5 | Device number for both frames |
| regAddr | input | 16 | Register address carried by the address frame |
| rdData | output | 16 | Value returned by the read frame |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line as seen at the pin |

## Verification
A sequencer that leaves a state one MDC cycle early or late shows at once as a misplaced driven bit or a wrongly timed release. Every transaction therefore records the drive enable and data at each rising MDC edge and compares them with the 129-cycle layout, segment by segment. The device model changes each data bit 250 ns after the rising edge and drives the inverse before that. A master that samples at the wrong edge therefore returns visibly corrupted data in the same transaction. A divider error shows up as a shortened MDC half-period, measured on every toggle. A busy or done error shows up as a missing, doubled or misaligned completion pulse, within a few cycles of the read frame ending.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  localparam int PHY_W      = 5;
  localparam int DEV_W      = 5;
  localparam int REG_W      = 16;
  localparam int DAT_W      = 16;
  localparam int WORD_W     = 32;
  localparam int PRE_LEN    = 32;
  localparam int ADR_HDR_LEN = 16;
  localparam int RD_HDR_LEN = 14;
  localparam int CNT_W      = $clog2(PRE_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_ADDR, ST_REL, ST_TA, ST_DATA, ST_FIN
  } mgmtState_t;

  typedef struct packed {
    logic loadArgs;
    logic loadWord;
    logic rdPhase;
    logic shiftOut;
    logic capture;
    logic commit;
    logic driveEn;
    logic forceOne;
  } mgmtStrobe_t;

  function automatic int halfCycles(longint clkHz, longint nsMin);
    longint q;
    q = (clkHz * nsMin + 64'd999_999_999) / 64'd1_000_000_000;
    if (q < 1) q = 1;
    return int'(q);
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
`timescale 1ns/1ps
module mgmt_mdc_gen #(
  parameter int HALF_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic fallTick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  logic [CW-1:0] cnt;
  logic halfEnd;

  assign halfEnd  = en && (cnt == CW'(HALF_CYC - 1));
  assign fallTick = halfEnd & mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (halfEnd) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_seq.sv
`timescale 1ns/1ps
module mgmt_seq
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        fallTick,
  output logic        busy,
  output logic        done,
  output mgmtStrobe_t stb
);
  mgmtState_t state;
  logic rdPh;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] limit;
  logic lastBit;

  always_comb begin
    case (state)
      ST_PRE:  limit = CNT_W'(PRE_LEN);
      ST_HDR:  limit = rdPh ? CNT_W'(RD_HDR_LEN) : CNT_W'(ADR_HDR_LEN);
      ST_ADDR: limit = CNT_W'(REG_W);
      ST_DATA: limit = CNT_W'(DAT_W);
      default: limit = CNT_W'(1);
    endcase
  end

  assign lastBit = (bitCnt == limit - 1'b1);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rdPh   <= 1'b0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state  <= ST_PRE;
          rdPh   <= 1'b0;
          bitCnt <= '0;
        end
      end else if (fallTick) begin
        if (!lastBit) begin
          bitCnt <= bitCnt + 1'b1;
        end else begin
          bitCnt <= '0;
          case (state)
            ST_PRE:  state <= ST_HDR;
            ST_HDR:  state <= rdPh ? ST_TA : ST_ADDR;
            ST_ADDR: state <= ST_REL;
            ST_REL: begin
              state <= ST_PRE;
              rdPh  <= 1'b1;
            end
            ST_TA:   state <= ST_DATA;
            ST_DATA: state <= ST_FIN;
            default: begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    stb.loadArgs = (state == ST_IDLE) && start;
    stb.loadWord = (state == ST_PRE) && fallTick && lastBit;
    stb.rdPhase  = rdPh;
    stb.shiftOut = fallTick && ((state == ST_HDR) || (state == ST_ADDR));
    stb.capture  = fallTick && (state == ST_DATA);
    stb.commit   = fallTick && (state == ST_FIN) && lastBit;
    stb.driveEn  = (state == ST_PRE) || (state == ST_HDR) || (state == ST_ADDR);
    stb.forceOne = (state == ST_PRE);
  end
endmodule

// File: rtl/mgmt_shift.sv
`timescale 1ns/1ps
module mgmt_shift
  import mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mgmtStrobe_t      stb,
  input  logic [PHY_W-1:0] phyAddr,
  input  logic [DEV_W-1:0] devAddr,
  input  logic [REG_W-1:0] regAddr,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic [DAT_W-1:0] rdData
);
  localparam int PAD_W = WORD_W - 4 - PHY_W - DEV_W;

  logic [PHY_W-1:0]  phyQ;
  logic [DEV_W-1:0]  devQ;
  logic [REG_W-1:0]  regQ;
  logic [WORD_W-1:0] txWord;
  logic [DAT_W-1:0]  rxShift;
  logic              capPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      phyQ    <= '0;
      devQ    <= '0;
      regQ    <= '0;
      txWord  <= '0;
      rxShift <= '0;
      capPend <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.loadArgs) begin
        phyQ <= phyAddr;
        devQ <= devAddr;
        regQ <= regAddr;
      end
      if (stb.loadWord) begin
        if (stb.rdPhase) txWord <= {4'b0011, phyQ, devQ, {PAD_W{1'b0}}};
        else             txWord <= {4'b0000, phyQ, devQ, 2'b10, regQ};
      end else if (stb.shiftOut) begin
        txWord <= {txWord[WORD_W-2:0], 1'b0};
      end
      capPend <= stb.capture;
      if (capPend) rxShift <= {rxShift[DAT_W-2:0], mdioIn};
      if (stb.commit) rdData <= rxShift;
    end
  end

  assign mdioOe  = stb.driveEn;
  assign mdioOut = stb.forceOne | (stb.driveEn & txWord[WORD_W-1]);
endmodule

// File: rtl/mgmt_ext_reader.sv
`timescale 1ns/1ps
module mgmt_ext_reader #(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int MIN_HALF_NS = 300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  devAddr,
  input  logic [15:0] regAddr,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  import mgmt_pkg::*;
  localparam int HALF_CYC = halfCycles(CLK_FREQ_HZ, MIN_HALF_NS);

  mgmtStrobe_t stb;
  logic fallTick;

  mgmt_mdc_gen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc), .fallTick(fallTick)
  );

  mgmt_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .fallTick(fallTick),
    .busy(busy), .done(done), .stb(stb)
  );

  mgmt_shift u_dp (
    .clk(clk), .rst(rst), .stb(stb), .phyAddr(phyAddr), .devAddr(devAddr),
    .regAddr(regAddr), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .rdData(rdData)
  );
endmodule

// File: rtl/mgmt_ext_reader_chk.sv
`timescale 1ns/1ps
module mgmt_ext_reader_chk #(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int MIN_HALF_NS = 300
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic [15:0] rdData
);
  localparam int HALF = mgmt_pkg::halfCycles(CLK_FREQ_HZ, MIN_HALF_NS);
  localparam int SW = $clog2(HALF + 2);

  logic mdcQ;
  logic [SW-1:0] sinceChg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdcQ     <= 1'b0;
      sinceChg <= SW'(HALF);
    end else begin
      mdcQ <= mdc;
      if (mdc != mdcQ) sinceChg <= SW'(1);
      else if (sinceChg < SW'(HALF)) sinceChg <= sinceChg + 1'b1;
      // R7: no MDC half-period shorter than the derived minimum
      a_r7_half_period: assert (!(mdc != mdcQ) || sinceChg >= SW'(HALF))
        else $error("MDC half-period too short");
    end
  end

  a_r8_done_on_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdData));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdioOe));
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (mdioOe && $past(mdioOe) && !$stable(mdioOut)) |-> $fell(mdc));
  a_r6_release_before_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(mdioOe));
endmodule

bind mgmt_ext_reader mgmt_ext_reader_chk #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ), .MIN_HALF_NS(MIN_HALF_NS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
);

// File: tb/mgmt_ext_reader_tb.sv
`timescale 1ns/1ps
module mgmt_ext_reader_tb;
  localparam int HALF_EXP = 30;
  localparam int NVEC = 5;
  // {port, device, register, data returned by the device model}
  localparam logic [41:0] VEC [NVEC] = '{
    {5'h01, 5'h01, 16'h0000, 16'hA5C3},
    {5'h1F, 5'h1F, 16'hFFFF, 16'hFFFF},
    {5'h00, 5'h00, 16'h8001, 16'h0000},
    {5'h15, 5'h0A, 16'h1234, 16'h8001},
    {5'h0A, 5'h15, 16'hC0DE, 16'h5A5A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [4:0] phyAddr = '0;
  logic [4:0] devAddr = '0;
  logic [15:0] regAddr = '0;
  logic [15:0] rdData;
  logic busy, done, mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mgmt_ext_reader u_dut (
    .clk(clk), .rst(rst), .start(start), .phyAddr(phyAddr), .devAddr(devAddr),
    .regAddr(regAddr), .rdData(rdData), .busy(busy), .done(done), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model and recorder
  logic recOe [0:139];
  logic recBit [0:139];
  int edgeIdx = 0;
  logic [15:0] phyData = '0;

  always @(posedge mdc) begin
    int idx;
    logic b;
    idx = edgeIdx;
    if (idx < 140) begin
      recOe[idx]  = mdioOe;
      recBit[idx] = mdioOut;
    end
    edgeIdx = edgeIdx + 1;
    if (idx >= 112 && idx <= 127) begin
      b = phyData[127 - idx];
      mdioIn = ~b;
      #250;
      mdioIn = b;
    end else begin
      mdioIn = 1'b1;
    end
  end

  int doneCnt = 0;
  int runLen = 1000000;
  int minHalf = 1000000;
  logic mdcPrev = 1'b0;
  always @(negedge clk) begin
    if (done) doneCnt++;
    if (mdc !== mdcPrev) begin
      if (runLen < minHalf) minHalf = runLen;
      runLen = 1;
    end else if (runLen < 1000000) begin
      runLen++;
    end
    mdcPrev = mdc;
  end

  function automatic logic [1:0] expAt(int i, logic [4:0] p, logic [4:0] d, logic [15:0] r);
    logic [15:0] hdrA;
    logic [13:0] hdrR;
    hdrA = {4'b0000, p, d, 2'b10};
    hdrR = {4'b0011, p, d};
    if (i < 32)       return 2'b11;
    else if (i < 48)  return {1'b1, hdrA[47 - i]};
    else if (i < 64)  return {1'b1, r[63 - i]};
    else if (i == 64) return 2'b00;
    else if (i < 97)  return 2'b11;
    else if (i < 111) return {1'b1, hdrR[110 - i]};
    else              return 2'b00;
  endfunction

  function automatic int segErr(int lo, int hi, logic [4:0] p, logic [4:0] d, logic [15:0] r);
    int n;
    logic [1:0] e;
    n = 0;
    for (int i = lo; i <= hi; i++) begin
      e = expAt(i, p, d, r);
      if (recOe[i] !== e[1]) n++;
      else if (e[1] && recBit[i] !== e[0]) n++;
    end
    return n;
  endfunction

  task automatic run_txn(logic [4:0] p, logic [4:0] d, logic [15:0] r,
                         logic [15:0] dat, bit poke);
    int cyc;
    int errs;
    phyData = dat;
    edgeIdx = 0;
    doneCnt = 0;
    @(negedge clk);
    start = 1'b1; phyAddr = p; devAddr = d; regAddr = r;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, 1);
    if (poke) begin
      repeat (2000) @(negedge clk);
      start = 1'b1; phyAddr = ~p; devAddr = ~d; regAddr = ~r;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check("R8 done seen", done, 1);
    check("R8 busy low at done", busy, 0);
    check("R5 read data", rdData, dat);
    repeat (5) @(negedge clk);
    check("R8 data held", rdData, dat);
    check("R8 one done pulse", doneCnt, 1);
    check("R6 total MDC cycles", edgeIdx, 129);
    check("R1 preamble", segErr(0, 31, p, d, r) + segErr(65, 96, p, d, r), 0);
    check("R2 address header", segErr(32, 47, p, d, r), 0);
    check("R3 register and release", segErr(48, 64, p, d, r), 0);
    check("R4 read header", segErr(97, 110, p, d, r), 0);
    check("R5 turnaround and data release", segErr(111, 127, p, d, r), 0);
    check("R6 final release", segErr(128, 128, p, d, r), 0);
    check("R7 idle quiet", {mdc, mdioOe}, 2'b00);
    if (poke) begin
      errs = segErr(0, 128, p, d, r);
      check("R9 start during busy ignored", errs + ((rdData == dat) ? 0 : 1), 0);
    end
  endtask

  initial begin
    #1_900_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset values
    check("R10 mdc", mdc, 0);
    check("R10 oe", mdioOe, 0);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 rdData", rdData, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", {busy, mdc, mdioOe}, 3'b000);

    for (int v = 0; v < NVEC; v++) begin
      run_txn(VEC[v][41:37], VEC[v][36:32], VEC[v][31:16], VEC[v][15:0], 1'b0);
    end
    // R9: start pulse in the middle of an exchange
    run_txn(5'h12, 5'h07, 16'h0F0F, 16'h3C96, 1'b1);
    // back-to-back request right after done
    run_txn(5'h03, 5'h1C, 16'h7FFE, 16'hC001, 1'b0);
    check("R7 min half-period", (minHalf >= HALF_EXP) ? 1 : 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule